// File: doc/BRIEF.md
# Word-Coalescing Store Buffer

This block sits between a core's store port and a data array protected by an error-correcting code over 4-byte granules. The array can accept a whole aligned word directly. A partial word forces the array to read the old word, merge in the new bytes and recompute the check bits. The buffer holds a few pending stores, each as one aligned word with a byte-enable mask. When a narrow store lands in the same word as the most recent pending entry, the buffer folds it into that entry, so that entries reach the array with complete masks as often as possible.

Stores enter on a valid/ready channel. `st_valid` may rise at any time. A store is taken on a cycle where both `st_valid` and `st_ready` are high. The sender must hold the request stable until it is taken. Commits leave on a second valid/ready channel. `wr_valid` is high whenever an entry is pending. The head entry retires on a cycle where `wr_valid` and `wr_ready` are both high. Entries retire strictly in the order they were created. Two counters report how many commits carried a complete mask and how many carried a partial one.

Top module: `coalesce_stbuf`

## Requirements
- R1: After reset, `wr_valid` is 0, `st_ready` is 1, `st_err` is 0 and both commit counters are 0.
- R2: The size codes are 0 for byte, 1 for halfword and 2 for word. A byte store at byte offset b (address bits [1:0]) places `st_data[7:0]` in lane b (`wr_data[8b+7:8b]`) and sets only mask bit b. `wr_addr` is the store address shifted right by two.
- R3: A halfword at offset 0 or 2 places `st_data[15:0]` in lanes 0–1 or lanes 2–3 respectively, with mask 0011 or 1100. A word store places all of `st_data` with mask 1111.
- R4: A store to the same aligned word as the youngest pending entry merges into that entry and takes no new slot. The new mask is the OR of the old and new masks. On overlapping lanes, the later bytes win.
- R5: A store to a different word takes a new entry. Entries commit in the order they were created.
- R6: Merging only ever targets the youngest entry. The sequence word A, word B, word A produces three commits.
- R7: The buffer holds 4 entries. With 4 entries pending, `st_ready` is 0 for an aligned store that does not hit the youngest word. It stays 1 for a store that does hit it.
- R8: A halfword at an odd address, a word at an address that is not a multiple of 4, or size code 3 is taken. Such a store creates or changes no entry and raises `st_err` for exactly the cycle after it was taken.
- R9: While `wr_valid` is 1 and `wr_ready` is 0, the head entry stays presented. `wr_addr` is unchanged and `wr_mask` only gains bits.
- R10: Each commit increments `full_cnt` if its mask is 1111, and increments `part_cnt` otherwise.
- R11: A store to the word of the only pending entry arrives in the same cycle that this entry commits. It does not merge and becomes a new entry.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| st_valid | input | 1 | Store request valid |
| st_ready | output | 1 | Store request can be taken |
| st_addr | input | AW | Byte address of the store |
| st_size | input | 2 | 0 byte, 1 halfword, 2 word, 3 invalid |
| st_data | input | 32 | Store data, right-aligned |
| st_err | output | 1 | One-cycle pulse for a rejected misaligned store |
| wr_valid | output | 1 | Head entry is presented to the array |
| wr_ready | input | 1 | Array takes the head entry |
| wr_addr | output | AW-2 | Aligned word address of the head entry |
| wr_data | output | 32 | Merged word data of the head entry |
| wr_mask | output | 4 | Byte enables of the head entry |
| full_cnt | output | CW | Commits with a complete mask |
| part_cnt | output | CW | Commits with a partial mask |

## Verification
A corrupted pointer or occupancy count shows up at the commit port. Commits appear out of creation order, get duplicated, or go missing, and this is visible once the affected entry reaches the head. A bad youngest-entry comparison shows up when a drain is held off: a merge that should happen yields two commits, or a merge that should not happen yields one. A lane or mask error is visible on `wr_data` and `wr_mask` in the cycle after the store is taken, and the counters expose it again at the commit.

// File: rtl/coalesce_stbuf_pkg.sv
package coalesce_stbuf_pkg;
  localparam int LANES = 4;
  localparam int WORD_W = 8 * LANES;
  typedef enum logic [1:0] {
    SZ_BYTE = 2'd0,
    SZ_HALF = 2'd1,
    SZ_WORD = 2'd2,
    SZ_BAD  = 2'd3
  } st_size_e;
endpackage

// File: rtl/cstb_lane_place.sv
module cstb_lane_place
  import coalesce_stbuf_pkg::*;
(
  input  logic [1:0]        offs,
  input  logic [1:0]        size,
  input  logic [WORD_W-1:0] din,
  output logic [WORD_W-1:0] lane_data,
  output logic [LANES-1:0]  lane_mask,
  output logic              misalign
);
  always_comb begin
    lane_data = din;
    lane_mask = '0;
    misalign  = 1'b0;
    case (st_size_e'(size))
      SZ_BYTE: begin
        lane_data = {LANES{din[7:0]}};
        lane_mask = LANES'(1) << offs;
      end
      SZ_HALF: begin
        lane_data = {(LANES/2){din[15:0]}};
        lane_mask = offs[1] ? 4'b1100 : 4'b0011;
        misalign  = offs[0];
      end
      SZ_WORD: begin
        lane_mask = '1;
        misalign  = (offs != 2'd0);
      end
      default: misalign = 1'b1;
    endcase
  end
endmodule

// File: rtl/cstb_lane_merge.sv
module cstb_lane_merge
  import coalesce_stbuf_pkg::*;
(
  input  logic [WORD_W-1:0] old_data,
  input  logic [LANES-1:0]  old_mask,
  input  logic [WORD_W-1:0] new_data,
  input  logic [LANES-1:0]  new_mask,
  output logic [WORD_W-1:0] out_data,
  output logic [LANES-1:0]  out_mask
);
  for (genvar g = 0; g < LANES; g++) begin : g_lane
    assign out_data[8*g +: 8] = new_mask[g] ? new_data[8*g +: 8] : old_data[8*g +: 8];
    assign out_mask[g]        = old_mask[g] | new_mask[g];
  end
endmodule

// File: rtl/cstb_commit_tally.sv
module cstb_commit_tally
  import coalesce_stbuf_pkg::*;
#(
  parameter int CW = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             commit,
  input  logic [LANES-1:0] commit_mask,
  output logic [CW-1:0]    full_cnt,
  output logic [CW-1:0]    part_cnt
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      full_cnt <= '0;
      part_cnt <= '0;
    end else if (commit) begin
      if (&commit_mask) full_cnt <= full_cnt + 1'b1;
      else              part_cnt <= part_cnt + 1'b1;
    end
  end

  logic [CW:0] tot;
  assign tot = {1'b0, full_cnt} + {1'b0, part_cnt};

  // R10: every commit moves exactly one of the two counters by one
  p_one_step_r10: assert property (@(posedge clk) disable iff (!rst_n)
    commit |=> (tot == $past(tot) + 1'b1) || (tot == '0 && $past(tot) != '0));
endmodule

// File: rtl/coalesce_stbuf.sv
module coalesce_stbuf
  import coalesce_stbuf_pkg::*;
#(
  parameter int AW    = 16,
  parameter int DEPTH = 4,
  parameter int CW    = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              st_valid,
  output logic              st_ready,
  input  logic [AW-1:0]     st_addr,
  input  logic [1:0]        st_size,
  input  logic [WORD_W-1:0] st_data,
  output logic              st_err,
  output logic              wr_valid,
  input  logic              wr_ready,
  output logic [AW-3:0]     wr_addr,
  output logic [WORD_W-1:0] wr_data,
  output logic [LANES-1:0]  wr_mask,
  output logic [CW-1:0]     full_cnt,
  output logic [CW-1:0]     part_cnt
);
  localparam int PW  = $clog2(DEPTH);
  localparam int WAW = AW - 2;

  logic [WAW-1:0]    e_addr [DEPTH];
  logic [WORD_W-1:0] e_data [DEPTH];
  logic [LANES-1:0]  e_mask [DEPTH];
  logic [PW-1:0]     head_q, tail_q, yng;
  logic [PW:0]       cnt_q;

  logic [WAW-1:0]    st_waddr;
  logic [WORD_W-1:0] in_data, mrg_data;
  logic [LANES-1:0]  in_mask, mrg_mask;
  logic              bad, pop, hit, fire, do_push, do_merge;

  assign st_waddr = st_addr[AW-1:2];
  assign yng      = tail_q - 1'b1;

  cstb_lane_place u_place (
    .offs(st_addr[1:0]), .size(st_size), .din(st_data),
    .lane_data(in_data), .lane_mask(in_mask), .misalign(bad)
  );

  cstb_lane_merge u_merge (
    .old_data(e_data[yng]), .old_mask(e_mask[yng]),
    .new_data(in_data), .new_mask(in_mask),
    .out_data(mrg_data), .out_mask(mrg_mask)
  );

  assign wr_valid = (cnt_q != '0);
  assign wr_addr  = e_addr[head_q];
  assign wr_data  = e_data[head_q];
  assign wr_mask  = e_mask[head_q];
  assign pop      = wr_valid && wr_ready;

  // youngest entry is a merge target unless it is the head leaving now
  assign hit      = wr_valid && (e_addr[yng] == st_waddr) &&
                    !(cnt_q == (PW+1)'(1) && pop);
  assign st_ready = bad || (cnt_q < (PW+1)'(DEPTH)) || hit;
  assign fire     = st_valid && st_ready;
  assign do_merge = fire && !bad && hit;
  assign do_push  = fire && !bad && !hit;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      head_q <= '0;
      tail_q <= '0;
      cnt_q  <= '0;
      st_err <= 1'b0;
      for (int i = 0; i < DEPTH; i++) begin
        e_addr[i] <= '0;
        e_data[i] <= '0;
        e_mask[i] <= '0;
      end
    end else begin
      st_err <= fire && bad;
      if (do_push) begin
        e_addr[tail_q] <= st_waddr;
        e_data[tail_q] <= in_data & {{8{in_mask[3]}}, {8{in_mask[2]}},
                                     {8{in_mask[1]}}, {8{in_mask[0]}}};
        e_mask[tail_q] <= in_mask;
        tail_q         <= tail_q + 1'b1;
      end
      if (do_merge) begin
        e_data[yng] <= mrg_data;
        e_mask[yng] <= mrg_mask;
      end
      if (pop) head_q <= head_q + 1'b1;
      cnt_q <= cnt_q + {{PW{1'b0}}, do_push} - {{PW{1'b0}}, pop};
    end
  end

  cstb_commit_tally #(.CW(CW)) u_tally (
    .clk(clk), .rst_n(rst_n), .commit(pop), .commit_mask(wr_mask),
    .full_cnt(full_cnt), .part_cnt(part_cnt)
  );

  // R7: occupancy never exceeds capacity
  p_no_overflow_r7: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= (PW+1)'(DEPTH));

  // R4: a merge leaves occupancy changed only by the drain
  p_merge_no_slot_r4: assert property (@(posedge clk) disable iff (!rst_n)
    do_merge |=> cnt_q == $past(cnt_q) - {{PW{1'b0}}, $past(pop)});

  // R8: a rejected store takes no slot
  p_err_no_slot_r8: assert property (@(posedge clk) disable iff (!rst_n)
    st_err |-> cnt_q == $past(cnt_q) - {{PW{1'b0}}, $past(pop)});

  // R9: a stalled head keeps its word and only gains bytes
  p_head_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_valid && !wr_ready) |=> wr_valid && $stable(wr_addr) &&
      ((wr_mask & $past(wr_mask)) == $past(wr_mask)));
endmodule

// File: tb/coalesce_stbuf_bench.sv
module coalesce_stbuf_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        st_valid = 1'b0, st_ready, st_err;
  logic [15:0] st_addr = '0;
  logic [1:0]  st_size = '0;
  logic [31:0] st_data = '0;
  logic        wr_valid, wr_ready = 1'b0;
  logic [13:0] wr_addr;
  logic [31:0] wr_data;
  logic [3:0]  wr_mask;
  logic [15:0] full_cnt, part_cnt;

  int n_chk = 0, n_err = 0;
  logic [13:0] cm_addr [128];
  logic [31:0] cm_data [128];
  logic [3:0]  cm_mask [128];
  int cm_n = 0;

  always #4 clk = ~clk;

  coalesce_stbuf u_coalesce_stbuf (
    .clk(clk), .rst_n(rst_n), .st_valid(st_valid), .st_ready(st_ready),
    .st_addr(st_addr), .st_size(st_size), .st_data(st_data), .st_err(st_err),
    .wr_valid(wr_valid), .wr_ready(wr_ready), .wr_addr(wr_addr),
    .wr_data(wr_data), .wr_mask(wr_mask), .full_cnt(full_cnt), .part_cnt(part_cnt)
  );

  always @(negedge clk)
    if (rst_n && wr_valid && wr_ready && cm_n < 128) begin
      cm_addr[cm_n] = wr_addr;
      cm_data[cm_n] = wr_data;
      cm_mask[cm_n] = wr_mask;
      cm_n++;
    end

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic cyc();
    @(posedge clk);
    #1;
  endtask

  task automatic put(input logic [15:0] a, input logic [1:0] sz, input logic [31:0] d);
    st_addr = a; st_size = sz; st_data = d; st_valid = 1'b1;
    for (int k = 0; k < 50 && !st_ready; k++) cyc();
    cyc();
    st_valid = 1'b0;
  endtask

  task automatic drain();
    wr_ready = 1'b1;
    for (int k = 0; k < 20 && wr_valid; k++) cyc();
    wr_ready = 1'b0;
  endtask

  task automatic chk_commit(input int idx, input logic [13:0] a, input logic [3:0] m,
                            input logic [31:0] d, input string tag);
    logic [31:0] dm;
    dm = {{8{m[3]}}, {8{m[2]}}, {8{m[1]}}, {8{m[0]}}};
    chk(cm_n > idx, {tag, " commit present"}, cm_n, idx + 1);
    if (cm_n > idx) begin
      chk(cm_addr[idx] == a, {tag, " addr"}, cm_addr[idx], a);
      chk(cm_mask[idx] == m, {tag, " mask"}, cm_mask[idx], m);
      chk((cm_data[idx] & dm) == (d & dm), {tag, " data"}, cm_data[idx] & dm, d & dm);
    end
  endtask

  task automatic t_reset();
    chk(wr_valid == 1'b0, "R1 wr_valid", wr_valid, 0);
    chk(st_ready == 1'b1, "R1 st_ready", st_ready, 1);
    chk(st_err == 1'b0, "R1 st_err", st_err, 0);
    chk(full_cnt == 0 && part_cnt == 0, "R1 counters", {full_cnt, part_cnt}, 0);
  endtask

  task automatic t_byte_lane();
    put(16'h0101, 2'd0, 32'h000000A5);
    chk(wr_valid == 1'b1, "R2 entry valid", wr_valid, 1);
    chk(wr_addr == 14'h0040, "R2 word addr", wr_addr, 32'h40);
    chk(wr_mask == 4'b0010, "R2 mask", wr_mask, 4'b0010);
    chk(wr_data[15:8] == 8'hA5, "R2 lane1", wr_data[15:8], 8'hA5);
    drain();
  endtask

  task automatic t_half_word();
    int b;
    b = cm_n;
    put(16'h0202, 2'd1, 32'h0000BEEF);
    put(16'h0300, 2'd2, 32'hCAFEF00D);
    drain();
    chk_commit(b, 14'h0080, 4'b1100, 32'hBEEF0000, "R3 half upper");
    chk_commit(b + 1, 14'h00C0, 4'b1111, 32'hCAFEF00D, "R3 word");
  endtask

  task automatic t_merge();
    int b;
    logic [15:0] f0;
    b = cm_n;
    f0 = full_cnt;
    put(16'h0400, 2'd0, 32'h11);
    put(16'h0401, 2'd0, 32'h22);
    put(16'h0402, 2'd1, 32'h4433);
    put(16'h0400, 2'd0, 32'h55);
    drain();
    chk(cm_n == b + 1, "R4 single commit", cm_n - b, 1);
    chk_commit(b, 14'h0100, 4'b1111, 32'h44332255, "R4 merged");
    chk(full_cnt == f0 + 1, "R10 full count", full_cnt, f0 + 1);
  endtask

  task automatic t_order();
    int b;
    b = cm_n;
    put(16'h0500, 2'd0, 32'hA1);
    put(16'h0504, 2'd0, 32'hB2);
    put(16'h0501, 2'd0, 32'hC3);
    drain();
    chk(cm_n == b + 3, "R6 three commits", cm_n - b, 3);
    chk_commit(b, 14'h0140, 4'b0001, 32'h000000A1, "R5 first");
    chk_commit(b + 1, 14'h0141, 4'b0001, 32'h000000B2, "R5 second");
    chk_commit(b + 2, 14'h0140, 4'b0010, 32'h0000C300, "R6 no old merge");
  endtask

  task automatic t_full();
    int b;
    b = cm_n;
    put(16'h0800, 2'd2, 32'h00000000);
    put(16'h0804, 2'd2, 32'h04040404);
    put(16'h0808, 2'd2, 32'h08080808);
    put(16'h080C, 2'd2, 32'h0C0C0C0C);
    st_addr = 16'h0810; st_size = 2'd0; st_data = 32'h66; st_valid = 1'b1;
    #1;
    chk(st_ready == 1'b0, "R7 full blocks new word", st_ready, 0);
    st_addr = 16'h080D; st_data = 32'h77;
    #1;
    chk(st_ready == 1'b1, "R7 full accepts merge", st_ready, 1);
    cyc();
    st_valid = 1'b0;
    drain();
    chk(cm_n == b + 4, "R7 four commits", cm_n - b, 4);
    chk_commit(b + 3, 14'h0203, 4'b1111, 32'h0C0C770C, "R7 merged into youngest");
  endtask

  task automatic t_misalign();
    put(16'h0701, 2'd1, 32'h1234);
    chk(st_err == 1'b1, "R8 err half odd", st_err, 1);
    chk(wr_valid == 1'b0, "R8 no entry", wr_valid, 0);
    cyc();
    chk(st_err == 1'b0, "R8 single pulse", st_err, 0);
    put(16'h0702, 2'd2, 32'h1);
    chk(st_err == 1'b1, "R8 err word", st_err, 1);
    put(16'h0700, 2'd3, 32'h1);
    chk(st_err == 1'b1, "R8 err size3", st_err, 1);
    chk(wr_valid == 1'b0, "R8 still empty", wr_valid, 0);
    cyc();
    chk(st_err == 1'b0, "R8 pulse ends", st_err, 0);
  endtask

  task automatic t_hold();
    put(16'h0900, 2'd0, 32'h3C);
    repeat (3) cyc();
    chk(wr_valid == 1'b1, "R9 still valid", wr_valid, 1);
    chk(wr_addr == 14'h0240, "R9 addr held", wr_addr, 14'h0240);
    chk(wr_mask == 4'b0001, "R9 mask held", wr_mask, 4'b0001);
    drain();
  endtask

  task automatic t_drain_race();
    int b;
    b = cm_n;
    wr_ready = 1'b1;
    put(16'h0600, 2'd0, 32'h01);
    put(16'h0601, 2'd0, 32'h02);
    drain();
    chk(cm_n == b + 2, "R11 two commits", cm_n - b, 2);
    chk_commit(b, 14'h0180, 4'b0001, 32'h01, "R11 first");
    chk_commit(b + 1, 14'h0180, 4'b0010, 32'h0200, "R11 second");
  endtask

  task automatic t_tally();
    int nf, np;
    nf = 0; np = 0;
    for (int i = 0; i < cm_n; i++)
      if (cm_mask[i] == 4'hF) nf++; else np++;
    chk(full_cnt == 16'(nf), "R10 full total", full_cnt, nf);
    chk(part_cnt == 16'(np), "R10 partial total", part_cnt, np);
  endtask

  initial begin
    #(8 * 200000);
    n_err++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #1;
    t_reset();
    rst_n = 1'b1;
    cyc();
    t_reset();
    t_byte_lane();
    t_half_word();
    t_merge();
    t_order();
    t_full();
    t_misalign();
    t_hold();
    t_drain_race();
    cyc();
    t_tally();
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end
endmodule